// File: doc/BRIEF.md
# Pipelined Register Write Dispatcher

This block sits between a host's memory-mapped write port and a deep rendering pipeline that draws triangles. Each host write names a register and carries 32 bits of data. A lookup on the register number picks one of four handling categories. Direct writes take effect at once. Ordered writes go through a command queue and are applied in arrival order. Drain-gated writes also go through the queue, but they are applied only once the pipeline reports that it is empty. Float writes are converted from single-precision floating point into the signed fixed-point form of a paired integer register, and the result is queued as a write to that register.

Two command registers, one integer and one float, each queue a triangle launch. When a launch reaches the head of the queue, the block presents the rendering state that all earlier queued writes have built up. It holds that state steady until the pipeline accepts the triangle. A setting written after a launch therefore never reaches that triangle.

Register numbers: 0 direct control, 1 texture mode, 2 blend mode, 3 depth mode (drain-gated), 4 vertex X (fixed point with FRAC_X fraction bits), 5 vertex Z (fixed point with FRAC_Z fraction bits), 6 triangle command, 7 float triangle command, 8 float vertex X (paired with 4), 9 float vertex Z (paired with 5). All other numbers are unmapped.

Top module: `regwr_dispatch`

## Requirements
- R1: A write accepted to register 0 appears on `dir_ctrl` at the next clock edge, even while the queue is blocked.
- R2: Writes to registers 1, 2, 4 and 5 are applied strictly in arrival order relative to each other and to launches, so every launched triangle carries exactly the latest earlier-queued values.
- R3: A texture-mode write queued between two launches is seen only by the second triangle.
- R4: A depth-mode write (register 3) that reaches the queue head is held, together with everything behind it, until `pipe_idle` is 1; it is applied only in a cycle where `pipe_idle` is 1.
- R5: A write to register 8 or 9 is converted from IEEE-754 single precision to signed fixed point. The conversion uses FRAC_X (default 4) or FRAC_Z (default 12) fraction bits, truncates toward zero and stores the result in register 4 or 5.
- R6: In float conversion, a NaN gives 0 and a zero or subnormal gives 0. An infinity or an out-of-range value saturates to 0x7FFFFFFF when positive and to 0x80000000 when negative.
- R7: A write to register 6 or 7 queues one launch. While `launch_valid` is 1 and `launch_ready` is 0, `launch_valid` stays 1 and all `tri_*` outputs stay stable.
- R8: The queue holds 16 entries. `wr_ready` is 0 while 16 entries are held, and no accepted write is lost.
- R9: Writes to unmapped register numbers (10 to 63) change neither `dir_ctrl` nor any triangle state.
- R10: After reset, `wr_ready` is 1, `launch_valid` is 0, and `dir_ctrl` and all `tri_*` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted when both are high; low when the queue is full |
| wr_addr | input | ADDR_W | Register number |
| wr_data | input | 32 | Write data (IEEE single for registers 8 and 9) |
| dir_ctrl | output | 32 | Direct control register |
| launch_valid | output | 1 | A triangle launch is offered |
| launch_ready | input | 1 | The pipeline accepts the launch |
| pipe_idle | input | 1 | No triangle or pixel is in flight |
| tri_tex | output | 32 | Texture mode for the launched triangle |
| tri_blend | output | 32 | Blend mode for the launched triangle |
| tri_depth | output | 32 | Depth mode for the launched triangle |
| tri_x | output | 32 | Vertex X, fixed point |
| tri_z | output | 32 | Vertex Z, fixed point |

## Verification
The assertions assume that the host keeps `wr_addr` and `wr_data` steady from the moment it raises `wr_valid` until the write is taken. They also assume that `pipe_idle` reports only idleness and carries no further timing relation to `launch_ready`. The stimulus drives host writes only on falling edges and holds them until acceptance. It changes `launch_ready` and `pipe_idle` only just after rising edges, choosing them at random in the random phase, and float data is built from random signs, exponents and mantissas so that both the saturating and the truncating ranges are hit.

// File: rtl/regwr_dispatch.sv
module regwr_dispatch #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6,
  parameter int FRAC_X = 4,
  parameter int FRAC_Z = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       dir_ctrl,
  output logic              launch_valid,
  input  logic              launch_ready,
  input  logic              pipe_idle,
  output logic [31:0]       tri_tex,
  output logic [31:0]       tri_blend,
  output logic [31:0]       tri_depth,
  output logic [31:0]       tri_x,
  output logic [31:0]       tri_z
);

  localparam int PW    = $clog2(DEPTH);
  localparam int CNT_W = PW + 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TEX   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_BLEND = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DEPTH = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_X     = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_Z     = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TRI   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_FTRI  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_FX    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_FZ    = ADDR_W'(9);

  typedef enum logic [1:0] {C_DIRECT, C_FIFO, C_STALL, C_FLOAT} cat_t;

  function automatic cat_t cat_of(input logic [ADDR_W-1:0] a);
    case (a)
      A_TEX, A_BLEND, A_X, A_Z, A_TRI, A_FTRI: return C_FIFO;
      A_DEPTH:                                 return C_STALL;
      A_FX, A_FZ:                              return C_FLOAT;
      default:                                 return C_DIRECT;
    endcase
  endfunction

  function automatic logic [31:0] f2fix(input logic [31:0] f, input int frac);
    logic [7:0]  e;
    logic [31:0] sig, mag;
    int          sh;
    e   = f[30:23];
    sig = {8'd0, 1'b1, f[22:0]};
    sh  = int'(e) - 150 + frac;
    mag = '0;
    if (e == 8'hFF && f[22:0] != 23'd0) return '0;
    if (e == 8'd0) return '0;
    if (e == 8'hFF || sh > 7) return f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    if (sh >= 0) mag = sig << sh;
    else if (sh > -32) mag = sig >> (-sh);
    return f[31] ? (~mag + 32'd1) : mag;
  endfunction

  logic [ADDR_W-1:0] q_a [DEPTH];
  logic [31:0]       q_d [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CNT_W-1:0]  count;

  cat_t              wcat;
  logic              fire, enq, pop, head_valid, head_launch, head_stall;
  logic [ADDR_W-1:0] enq_a, head_a;
  logic [31:0]       enq_d;

  assign wcat  = cat_of(wr_addr);
  assign fire  = wr_valid && wr_ready;
  assign enq   = fire && (wcat != C_DIRECT);
  assign enq_a = (wr_addr == A_FX)   ? A_X :
                 (wr_addr == A_FZ)   ? A_Z :
                 (wr_addr == A_FTRI) ? A_TRI : wr_addr;
  assign enq_d = (wcat == C_FLOAT) ? f2fix(wr_data, (wr_addr == A_FX) ? FRAC_X : FRAC_Z)
                                   : wr_data;

  assign wr_ready     = (count != CNT_W'(DEPTH));
  assign head_valid   = (count != '0);
  assign head_a       = q_a[rp];
  assign head_launch  = head_valid && (head_a == A_TRI);
  assign head_stall   = head_valid && (cat_of(head_a) == C_STALL);
  assign launch_valid = head_launch;
  assign pop = head_valid && (head_launch ? launch_ready :
                              head_stall  ? pipe_idle : 1'b1);

  always_ff @(posedge clk) begin
    if (enq) begin
      q_a[wp] <= enq_a;
      q_d[wp] <= enq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (enq) wp <= wp + PW'(1);
      if (pop) rp <= rp + PW'(1);
      count <= count + CNT_W'(enq) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_ctrl  <= '0;
      tri_tex   <= '0;
      tri_blend <= '0;
      tri_depth <= '0;
      tri_x     <= '0;
      tri_z     <= '0;
    end else begin
      if (fire && wr_addr == A_CTRL) dir_ctrl <= wr_data;
      if (pop && !head_launch) begin
        case (head_a)
          A_TEX:   tri_tex   <= q_d[rp];
          A_BLEND: tri_blend <= q_d[rp];
          A_DEPTH: tri_depth <= q_d[rp];
          A_X:     tri_x     <= q_d[rp];
          A_Z:     tri_z     <= q_d[rp];
          default: ;
        endcase
      end
    end
  end

  AST_DIRECT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    fire && wr_addr == A_CTRL |=> dir_ctrl == $past(wr_data)); // R1

  AST_STALL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tri_depth) |-> $past(pipe_idle)); // R4

  AST_LAUNCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid && !launch_ready |=> launch_valid && $stable(tri_tex) && $stable(tri_blend)
      && $stable(tri_depth) && $stable(tri_x) && $stable(tri_z)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R8

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !pop |=> count == CNT_W'(DEPTH)); // R8

  always_comb begin
    if (rst_n && wcat == C_FLOAT && wr_data[30:23] == 8'hFF && wr_data[22:0] != 23'd0)
      AST_NAN_ZERO: assert (enq_d == 32'd0); // R6
  end

endmodule

// File: tb/test_regwr_dispatch.sv
module test_regwr_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] dir_ctrl;
  logic        launch_valid;
  logic        launch_ready = 1'b0;
  logic        pipe_idle = 1'b1;
  logic [31:0] tri_tex, tri_blend, tri_depth, tri_x, tri_z;

  always #10 clk = ~clk;

  regwr_dispatch i_regwr_dispatch (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .dir_ctrl(dir_ctrl),
    .launch_valid(launch_valid), .launch_ready(launch_ready), .pipe_idle(pipe_idle),
    .tri_tex(tri_tex), .tri_blend(tri_blend), .tri_depth(tri_depth),
    .tri_x(tri_x), .tri_z(tri_z));

  int checks = 0, errors = 0;
  int n_exp = 0, n_got = 0;
  logic [159:0] e_st [512];
  string        e_tag [512];
  string        cur_tag = "R2";
  logic [31:0]  m_dir = 0, m_tex = 0, m_blend = 0, m_depth = 0, m_x = 0, m_z = 0;
  bit           rnd_on = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fix(input logic [31:0] f, input int frac);
    int  e, p, mag;
    real v;
    e = int'(f[30:23]);
    if (e == 255 && f[22:0] != 0) return 32'd0;
    if (e == 0) return 32'd0;
    if (e == 255) return f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    v = 8388608.0 + real'(f[22:0]);
    p = e - 150 + frac;
    if (p >= 0) for (int i = 0; i < p; i++) v = v * 2.0;
    else        for (int i = 0; i < -p; i++) v = v / 2.0;
    if (v >= 2147483648.0) return f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    mag = $rtoi(v);
    return f[31] ? 32'(-mag) : 32'(mag);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    case (a)
      0: m_dir = d;
      1: m_tex = d;
      2: m_blend = d;
      3: m_depth = d;
      4: m_x = d;
      5: m_z = d;
      6, 7: begin
        e_st[n_exp] = {m_tex, m_blend, m_depth, m_x, m_z};
        e_tag[n_exp] = cur_tag;
        n_exp++;
      end
      8: m_x = ref_fix(d, 4);
      9: m_z = ref_fix(d, 12);
      default: ;
    endcase
  endtask

  task automatic set_ctl(input logic lr, input logic idle);
    @(posedge clk); #1;
    launch_ready = lr; pipe_idle = idle;
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && launch_valid && launch_ready) begin
      if (n_got < n_exp)
        check({tri_tex, tri_blend, tri_depth, tri_x, tri_z} == e_st[n_got], e_tag[n_got],
              "launch state", {tri_tex, tri_blend, tri_depth, tri_x, tri_z}, e_st[n_got]);
      else
        check(1'b0, "R2", "unexpected launch", 160'(n_got), 160'(n_exp));
      n_got++;
    end
  end

  always @(posedge clk) begin
    if (rnd_on) begin
      #1;
      launch_ready = ($urandom % 2) != 0;
      pipe_idle    = ($urandom % 4) != 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 160'(n_got), 160'(n_exp));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] t1, t2, d;
    logic [5:0]  a;
    void'($urandom(32'd2024));
    idle_cycles(5);
    rst_n = 1'b1;
    idle_cycles(1);
    // R10 reset state
    check(wr_ready == 1'b1 && launch_valid == 1'b0, "R10", "handshake after reset",
          160'({wr_ready, launch_valid}), 160'(2'b10));
    check({dir_ctrl, tri_tex, tri_blend, tri_depth, tri_x, tri_z} == '0, "R10",
          "registers after reset", 160'({tri_tex, tri_blend, tri_depth, tri_x, tri_z}), 160'd0);

    // R1 direct write
    wr(6'd0, 32'hA5A5_0001);
    check(dir_ctrl == 32'hA5A5_0001, "R1", "direct write", 160'(dir_ctrl), 160'(32'hA5A5_0001));

    // R3 and R7: texture write between two launches
    cur_tag = "R3";
    t1 = 32'h0000_1111; t2 = 32'h0000_2222;
    wr(6'd1, t1); wr(6'd6, 0); wr(6'd1, t2); wr(6'd7, 0);
    idle_cycles(3);
    check(launch_valid && tri_tex == t1, "R3", "first triangle texture", 160'(tri_tex), 160'(t1));
    idle_cycles(5);
    check(launch_valid && tri_tex == t1, "R7", "held launch stable", 160'({launch_valid, tri_tex}),
          160'({1'b1, t1}));
    set_ctl(1'b1, 1'b1);
    idle_cycles(10);
    check(n_got == n_exp, "R3", "both triangles launched", 160'(n_got), 160'(n_exp));
    check(tri_tex == t2, "R3", "texture after second", 160'(tri_tex), 160'(t2));

    // R4 drain-gated write
    cur_tag = "R4";
    set_ctl(1'b1, 1'b0);
    wr(6'd3, 32'h0000_00D3); wr(6'd6, 0);
    wr(6'd0, 32'h0000_0077);
    check(dir_ctrl == 32'h77, "R1", "direct write while queue stalled", 160'(dir_ctrl), 160'(32'h77));
    idle_cycles(20);
    check(n_got == n_exp - 1 && !launch_valid && tri_depth == 0, "R4", "held until idle",
          160'({n_got, tri_depth}), 160'({n_exp - 1, 32'd0}));
    set_ctl(1'b1, 1'b1);
    idle_cycles(10);
    check(n_got == n_exp, "R4", "released after idle", 160'(n_got), 160'(n_exp));

    // R5 conversion with truncation
    cur_tag = "R5";
    wr(6'd8, 32'h3FC0_0000); wr(6'd9, 32'hC030_0000); wr(6'd6, 0);
    wr(6'd8, 32'h3D00_0000); wr(6'd9, 32'hBF80_0001); wr(6'd7, 0);
    idle_cycles(10);
    check(tri_x == 32'd0 && tri_z == 32'hFFFF_F000, "R5", "truncation toward zero",
          160'({tri_x, tri_z}), 160'({32'd0, 32'hFFFF_F000}));

    // R6 special values
    cur_tag = "R6";
    wr(6'd8, 32'h7FC0_0000); wr(6'd9, 32'h7F80_0000); wr(6'd6, 0);
    wr(6'd8, 32'hE0AD_78EC); wr(6'd9, 32'h0040_0000); wr(6'd6, 0);
    idle_cycles(10);
    check(tri_x == 32'h8000_0000 && tri_z == 32'd0, "R6", "negative saturation and subnormal",
          160'({tri_x, tri_z}), 160'({32'h8000_0000, 32'd0}));

    // R9 unmapped writes
    cur_tag = "R9";
    wr(6'd12, 32'hDEAD_BEEF); wr(6'd63, 32'h1234_5678);
    idle_cycles(4);
    check(dir_ctrl == m_dir, "R9", "unmapped leaves direct reg", 160'(dir_ctrl), 160'(m_dir));
    wr(6'd6, 0);
    idle_cycles(6);

    // R8 full queue
    cur_tag = "R8";
    set_ctl(1'b0, 1'b1);
    wr(6'd6, 0);
    for (int i = 1; i < 16; i++) wr(6'd1, 32'(32'h100 + i));
    idle_cycles(2);
    check(wr_ready == 1'b0, "R8", "ready low when full", 160'(wr_ready), 160'd0);
    set_ctl(1'b1, 1'b1);
    wr(6'd6, 0);
    idle_cycles(30);
    check(n_got == n_exp && tri_tex == 32'h10F, "R8", "no write lost", 160'({n_got, tri_tex}),
          160'({n_exp, 32'h10F}));

    // R2 random ordering
    cur_tag = "R2";
    rnd_on = 1;
    for (int i = 0; i < 400; i++) begin
      a = 6'($urandom % 16);
      if (a == 8 || a == 9)
        d = {1'($urandom % 2), 8'(100 + $urandom % 70), 23'($urandom)};
      else
        d = $urandom;
      wr(a, d);
      if (a == 0)
        check(dir_ctrl == d, "R1", "random direct write", 160'(dir_ctrl), 160'(d));
    end
    wr(6'd6, 0);
    rnd_on = 0;
    set_ctl(1'b1, 1'b1);
    idle_cycles(100);
    check(n_got == n_exp, "R2", "all launches delivered", 160'(n_got), 160'(n_exp));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule